// File: doc/BRIEF.md
# Link Value Store with Consumption Tracking

This block holds the latest value of every directed link between cells in a simulator that evaluates the cells of a parallel design one at a time. Each link has a single storage word that is overwritten in place. Next to each word sits a consumption flag that records whether the current value has already been fetched by the cell the link feeds. A cell counts as settled only when every one of its input links has been consumed since it last changed.

The evaluation engine uses the block through four operations. It raises a cycle-start pulse at every simulated clock boundary. It presents a cell number to fetch that cell's input links. It pulses a read strobe once the cell has been evaluated. It writes each output link the cell produces. A registered per-cell settled vector tells the engine which cells still need (re)evaluation. The table that maps each cell's input slots to link numbers is a parameter.

Top module: `link_track_mem`

## Requirements
- R1: After reset every link word holds zero, every consumption flag is clear, and the settled vector is all zeros.
- R2: A write with `wr_link` below NUM_LINKS stores `wr_data` in that link's word. `rd_data` slot s (bits [s*LINK_W +: LINK_W]) shows, without a clock, the word of the link mapped to slot s of cell `rd_cell`. An unused slot reads zero. The default map gives cell 0 links {3,4}, cell 1 {0, unused}, cell 2 {1,5} and cell 3 {2, unused}, listed in slot order.
- R3: The read strobe marks the flags of all links mapped to the slots of `rd_cell` as consumed.
- R4: A cycle-start pulse clears all consumption flags and overrides any mark made in the same clock.
- R5: A write whose data differs from the stored word clears that link's flag, and this overrides a mark on the same link in the same clock.
- R6: A write whose data equals the stored word leaves that link's flag unchanged.
- R7: `settled[c]` is a register that shows, one clock after the flags change, whether every used slot of cell c has its flag set. Unused slots count as consumed.
- R8: A write with `wr_link` at or above NUM_LINKS changes no link word and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | Simulated-cycle boundary: clear all flags |
| wr_en | input | 1 | Link write strobe |
| wr_link | input | LIDX_W | Link number to write |
| wr_data | input | LINK_W | New link value |
| rd_en | input | 1 | Mark inputs of `rd_cell` as consumed |
| rd_cell | input | CIDX_W | Cell whose input links are fetched |
| rd_data | output | MAX_IN*LINK_W | Input link words of `rd_cell`, one per slot |
| settled | output | NUM_CELLS | Registered per-cell stability |

## Verification
The bench uses the default build of four cells with two input slots each, six 8-bit links, and a map in which two cells leave one slot unused. With that shape, shared link numbers, unused-slot handling and out-of-range link numbers (6 and 7 fit in the 3-bit index) are all within reach. A behavioural model checks every clock. Same-clock collisions of mark, invalidating write and cycle start are driven both on purpose and through a long random phase.

// File: rtl/link_track_mem.sv
module link_track_mem #(
  parameter int NUM_CELLS = 4,
  parameter int MAX_IN    = 2,
  parameter int NUM_LINKS = 6,
  parameter int LINK_W    = 8,
  localparam int CIDX_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int LIDX_W   = $clog2(NUM_LINKS + 1),
  parameter logic [NUM_CELLS*MAX_IN*LIDX_W-1:0] SLOT_MAP =
    {3'd6, 3'd2, 3'd5, 3'd1, 3'd6, 3'd0, 3'd4, 3'd3}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_start,
  input  logic                     wr_en,
  input  logic [LIDX_W-1:0]        wr_link,
  input  logic [LINK_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [CIDX_W-1:0]        rd_cell,
  output logic [MAX_IN*LINK_W-1:0] rd_data,
  output logic [NUM_CELLS-1:0]     settled
);

  logic [LINK_W-1:0]    link_q [NUM_LINKS];
  logic [NUM_LINKS-1:0] hbr_q, mark, inval, hbr_d;
  logic [NUM_CELLS-1:0] settled_d;
  logic [NUM_LINKS*LINK_W-1:0] link_flat;

  wire wr_ok   = wr_en && (32'(wr_link) < NUM_LINKS);
  wire cell_ok = 32'(rd_cell) < NUM_CELLS;

  function automatic logic [LIDX_W-1:0] slot_link(input int c, input int s);
    return SLOT_MAP[(c*MAX_IN+s)*LIDX_W +: LIDX_W];
  endfunction

  for (genvar s = 0; s < MAX_IN; s++) begin : g_rd
    wire [LIDX_W-1:0] lk = slot_link(int'(rd_cell), s);
    assign rd_data[s*LINK_W +: LINK_W] =
      (cell_ok && 32'(lk) < NUM_LINKS) ? link_q[lk] : '0;
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_flat
    assign link_flat[i*LINK_W +: LINK_W] = link_q[i];
  end

  always_comb begin
    logic [LIDX_W-1:0] lk;
    mark  = '0;
    inval = '0;
    for (int s = 0; s < MAX_IN; s++) begin
      lk = slot_link(int'(rd_cell), s);
      if (rd_en && cell_ok && 32'(lk) < NUM_LINKS) mark[lk] = 1'b1;
    end
    if (wr_ok && wr_data != link_q[wr_link]) inval[wr_link] = 1'b1;
  end

  assign hbr_d = cyc_start ? '0 : ((hbr_q | mark) & ~inval);

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_stab
    always_comb begin
      logic [LIDX_W-1:0] lk;
      settled_d[c] = 1'b1;
      for (int s = 0; s < MAX_IN; s++) begin
        lk = slot_link(c, s);
        if (32'(lk) < NUM_LINKS && !hbr_q[lk]) settled_d[c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbr_q   <= '0;
      settled <= '0;
      for (int i = 0; i < NUM_LINKS; i++) link_q[i] <= '0;
    end else begin
      hbr_q   <= hbr_d;
      settled <= settled_d;
      if (wr_ok) link_q[wr_link] <= wr_data;
    end
  end

endmodule

// File: rtl/link_track_chk.sv
module link_track_chk #(
  parameter int NUM_CELLS = 4,
  parameter int MAX_IN    = 2,
  parameter int NUM_LINKS = 6,
  parameter int LINK_W    = 8,
  parameter int CIDX_W    = 2,
  parameter int LIDX_W    = 3,
  parameter logic [NUM_CELLS*MAX_IN*LIDX_W-1:0] SLOT_MAP = '0
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cyc_start,
  input logic                        wr_en,
  input logic [LIDX_W-1:0]           wr_link,
  input logic [LINK_W-1:0]           wr_data,
  input logic                        rd_en,
  input logic [CIDX_W-1:0]           rd_cell,
  input logic [NUM_CELLS-1:0]        settled,
  input logic [NUM_LINKS-1:0]        hbr_q,
  input logic [NUM_LINKS*LINK_W-1:0] link_flat
);

  wire wr_ok = wr_en && (32'(wr_link) < NUM_LINKS);
  wire [LINK_W-1:0] cur = wr_ok ? link_flat[int'(wr_link)*LINK_W +: LINK_W] : '0;

  logic [NUM_CELLS-1:0] has_in;
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_has
    always_comb begin
      has_in[c] = 1'b0;
      for (int s = 0; s < MAX_IN; s++)
        if (32'(SLOT_MAP[(c*MAX_IN+s)*LIDX_W +: LIDX_W]) < NUM_LINKS) has_in[c] = 1'b1;
    end
  end

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> hbr_q == '0);

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> link_flat[int'($past(wr_link))*LINK_W +: LINK_W] == $past(wr_data));

  assert_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_data != cur) |=> !hbr_q[$past(wr_link)]);

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_data == cur && !cyc_start && !rd_en) |=>
      hbr_q[$past(wr_link)] == $past(hbr_q[wr_link]));

  assert_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> ##1 (settled & has_in) == '0);

  for (genvar s = 0; s < MAX_IN; s++) begin : g_mark
    wire [LIDX_W-1:0] lk = (32'(rd_cell) < NUM_CELLS) ?
      SLOT_MAP[(int'(rd_cell)*MAX_IN+s)*LIDX_W +: LIDX_W] : LIDX_W'(NUM_LINKS);
    assert_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !cyc_start && 32'(lk) < NUM_LINKS && !(wr_en && wr_link == lk))
        |=> hbr_q[$past(lk)]);
  end

endmodule

bind link_track_mem link_track_chk #(
  .NUM_CELLS(NUM_CELLS), .MAX_IN(MAX_IN), .NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W),
  .CIDX_W(CIDX_W), .LIDX_W(LIDX_W), .SLOT_MAP(SLOT_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .wr_en(wr_en),
  .wr_link(wr_link), .wr_data(wr_data), .rd_en(rd_en), .rd_cell(rd_cell),
  .settled(settled), .hbr_q(hbr_q), .link_flat(link_flat)
);

// File: tb/link_track_mem_tb.sv
module link_track_mem_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [2:0] wl = '0;
  logic [7:0] wd = '0;
  logic [1:0] rc = '0;
  logic [15:0] rd_data;
  logic [3:0]  settled;

  int n_chk = 0, n_err = 0;
  int bmap [4][2] = '{'{3, 4}, '{0, -1}, '{1, 5}, '{2, -1}};
  int mem [6];
  bit flg [6];
  bit stab [4];
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_track_mem u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cs), .wr_en(we), .wr_link(wl),
    .wr_data(wd), .rd_en(re), .rd_cell(rc), .rd_data(rd_data), .settled(settled)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin mem[i] = 0; flg[i] = 0; end
      for (int c = 0; c < 4; c++) stab[c] = 0;
    end else begin
      bit chg;
      for (int c = 0; c < 4; c++) begin
        stab[c] = 1;
        for (int s = 0; s < 2; s++)
          if (bmap[c][s] >= 0 && !flg[bmap[c][s]]) stab[c] = 0;
      end
      chg = we && wl < 6 && mem[wl] != int'(wd);
      if (cs) for (int i = 0; i < 6; i++) flg[i] = 0;
      else begin
        if (re) for (int s = 0; s < 2; s++) if (bmap[rc][s] >= 0) flg[bmap[rc][s]] = 1;
        if (chg) flg[wl] = 0;
      end
      if (we && wl < 6) mem[wl] = int'(wd);
    end
  end

  task automatic compare(string tag);
    logic [15:0] exp_rd;
    logic [3:0]  exp_st;
    for (int s = 0; s < 2; s++)
      exp_rd[s*8 +: 8] = (bmap[rc][s] >= 0) ? 8'(mem[bmap[rc][s]]) : 8'h00;
    for (int c = 0; c < 4; c++) exp_st[c] = stab[c];
    n_chk++;
    if (rd_data !== exp_rd) begin
      n_err++;
      $display("FAIL %s rd_data: actual=%h expected=%h", tag, rd_data, exp_rd);
    end
    n_chk++;
    if (settled !== exp_st) begin
      n_err++;
      $display("FAIL %s settled: actual=%b expected=%b", tag, settled, exp_st);
    end
  endtask

  task automatic step(bit c_s, bit w_e, int w_l, int w_d, bit r_e, int r_c, string tag);
    @(negedge clk);
    cs = c_s; we = w_e; wl = 3'(w_l); wd = 8'(w_d); re = r_e; rc = 2'(r_c);
    #1 compare(tag);
  endtask

  initial begin
    #200000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 compare("R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 2, "R1");
    step(1, 0, 0, 0, 0, 0, "R4");
    step(0, 1, 3, 8'h11, 0, 0, "R2");
    step(0, 1, 4, 8'h22, 0, 0, "R2");
    step(0, 1, 0, 8'h33, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 1, 1, "R3");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 1, 3, 8'h11, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 1, 3, 8'h12, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 0, "R3");
    step(0, 1, 4, 8'h23, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 2, "R3");
    step(1, 0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, "R3");
    step(0, 1, 6, 8'hEE, 0, 0, "R8");
    step(0, 1, 7, 8'hDD, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 2, "R8");
    for (int i = 0; i < 600; i++)
      step(($urandom % 16) == 0, $urandom % 2, $urandom % 8, $urandom % 4,
           $urandom % 2, $urandom % 4, "R5");
    step(0, 0, 0, 0, 0, 0, "R7");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule